// File: doc/BRIEF.md
# Sequencer for a Successive-Approximation Converter

This block holds the digital control of a successive-approximation converter. It divides the system clock into a converter clock and counts half-periods of that clock. From this count it places the sample-and-hold strobe, takes one comparator decision per converter cycle and raises a completion flag. A conversion can be started by software or by a trigger pulse, and a free-running option chains conversions back to back. The length of a conversion and its sample point depend on its kind. The first conversion after the block is enabled is the long one. A software-started conversion is the normal one. A conversion started by a trigger has its own timing.

The channel and reference fields written by software reach the analog side through a shadow copy. The copy follows the written value while the converter is idle. It freezes when a conversion starts, so that the sampled input stays put for the whole sampling window. It follows the written value again for the last eight converter cycles of each conversion, so that the next channel can be set up ahead of the next conversion. The analog part is outside the block. The only signal it returns is the comparator bit.

Top module: `adc_seq_top`

## Requirements
- R1: A synchronous reset clears the completion flag, the sample strobe, the result and both shadow fields to zero.
- R2: A start request sampled at system clock edge N begins the conversion at edge N+1, and the half-period count runs from that edge.
- R3: The first conversion after reset uses the long timing. The sample strobe goes high one system cycle after 27 half-periods, and the flag sets 50 half-periods after the conversion begins.
- R4: A conversion started by start_wr, other than the first, samples after 7 half-periods and completes after 31.
- R5: With auto_en high, a one-cycle trig pulse starts a conversion that samples after 4 half-periods and completes after 32. With auto_en low, trig has no effect.
- R6: One half-period lasts 2^presc_sel system cycles (presc_sel 0 to 7). The value is captured when a conversion begins, so later changes to presc_sel do not alter that conversion.
- R7: Every second half-period after the sample point, the comparator bit is stored into the result. The first bit stored goes to result bit 9 and the tenth goes to bit 0. result_o is updated in the same edge that sets the flag.
- R8: flag_o stays high until flag_clr is high on a clock edge. A completion in the same edge as a clear leaves the flag set.
- R9: The shadow fields copy mux_wr and ref_wr on every edge while idle, including the edge on which a conversion begins. From the next edge they hold their value until the half-period count reaches total-16. They copy again from the edge after that.
- R10: With free_run high, a new conversion with normal timing begins on the edge that completes the previous one. Lowering free_run stops the chain after the conversion that is running.
- R11: A start request that arrives while a conversion is running is ignored and starts nothing afterwards.
- R12: Holding enable low for at least one edge makes the next conversion use the long first-conversion timing again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Converter enable; while low, no conversion starts |
| start_wr | input | 1 | Software start request pulse |
| trig | input | 1 | Trigger event pulse |
| auto_en | input | 1 | Lets trig start conversions |
| free_run | input | 1 | Chains conversions back to back |
| presc_sel | input | 3 | Half-period length select, 2^value system cycles |
| mux_wr | input | 4 | Software-written channel select |
| ref_wr | input | 2 | Software-written reference select |
| cmp | input | 1 | Comparator decision from the analog side |
| flag_clr | input | 1 | Write-one clear of the completion flag |
| mux_q | output | 4 | Shadow channel select driven to the analog side |
| ref_q | output | 2 | Shadow reference select driven to the analog side |
| sample_o | output | 1 | One-cycle sample-and-hold strobe |
| result_o | output | 10 | Conversion result |
| flag_o | output | 1 | Completion flag |

## Verification
The assertions take for granted that enable stays high while a conversion runs and that flag_clr is a short pulse. They also assume the comparator bit is valid at the edge where a decision is stored. The stimulus never lowers enable during a conversion. The comparator model in the bench drives the bit of the expected value only in the cycle before each decision edge, and drives zero at all other times. Channel changes are made only after the conversion has begun, never in the two edges that follow a start request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int HC_W = 6;
  localparam int LOCK_HALVES = 16;

  typedef enum logic [1:0] {
    MODE_FIRST  = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_AUTO   = 2'd2
  } conv_mode_e;

  function automatic logic [HC_W-1:0] total_halves(conv_mode_e m);
    case (m)
      MODE_FIRST: total_halves = HC_W'(50);
      MODE_AUTO:  total_halves = HC_W'(32);
      default:    total_halves = HC_W'(31);
    endcase
  endfunction

  function automatic logic [HC_W-1:0] sample_halves(conv_mode_e m);
    case (m)
      MODE_FIRST: sample_halves = HC_W'(27);
      MODE_AUTO:  sample_halves = HC_W'(4);
      default:    sample_halves = HC_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
  parameter int PSEL_W = 3,
  localparam int CNT_W = (1 << PSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  input  logic [PSEL_W-1:0] sel,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;

  assign span  = (CNT_W+1)'(1) << sel;
  assign limit = CNT_W'(span - 1'b1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  a_r6_count_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q <= limit);
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start_wr,
  input  logic              trig,
  input  logic              auto_en,
  input  logic              free_run,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic              tick,
  output logic              busy,
  output logic [PSEL_W-1:0] sel_q,
  output logic              go,
  output logic              at_sample,
  output logic              at_done,
  output logic              open_win
);
  localparam logic [HC_W-1:0] LOCK_H = HC_W'(LOCK_HALVES);

  logic            req_q, req_auto_q, first_pend_q, busy_q;
  logic [HC_W-1:0] hc_q, hc_nxt, s_lim, t_lim;
  conv_mode_e      mode_q;
  logic            launch, chain;

  assign s_lim     = sample_halves(mode_q);
  assign t_lim     = total_halves(mode_q);
  assign hc_nxt    = hc_q + 1'b1;
  assign at_sample = busy_q && tick && (hc_nxt == s_lim);
  assign at_done   = busy_q && tick && (hc_nxt == t_lim);
  assign chain     = at_done && free_run && enable;
  assign launch    = req_q && !busy_q && enable;
  assign go        = launch || chain;
  assign open_win  = !busy_q || (hc_q >= t_lim - LOCK_H);
  assign busy      = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q        <= 1'b0;
      req_auto_q   <= 1'b0;
      first_pend_q <= 1'b1;
      busy_q       <= 1'b0;
      hc_q         <= '0;
      mode_q       <= MODE_NORMAL;
      sel_q        <= '0;
    end else begin
      req_q      <= (start_wr || (trig && auto_en)) && !busy_q && enable;
      req_auto_q <= trig && auto_en && !start_wr;
      if (!enable) first_pend_q <= 1'b1;
      if (launch) begin
        busy_q       <= 1'b1;
        hc_q         <= '0;
        sel_q        <= presc_sel;
        first_pend_q <= 1'b0;
        mode_q       <= first_pend_q ? MODE_FIRST :
                        (req_auto_q ? MODE_AUTO : MODE_NORMAL);
      end else if (chain) begin
        hc_q   <= '0;
        sel_q  <= presc_sel;
        mode_q <= MODE_NORMAL;
      end else if (at_done || !enable) begin
        busy_q <= 1'b0;
        hc_q   <= '0;
      end else if (busy_q && tick) begin
        hc_q <= hc_nxt;
      end
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> hc_q < t_lim);
  a_r9_sample_locked: assert property (@(posedge clk) disable iff (rst)
    at_sample |-> !open_win);
  a_r11_no_launch_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q && !at_done |=> busy_q || !enable);
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int RES_W = 10,
  localparam int PTR_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             at_sample,
  input  logic             at_done,
  input  logic             busy,
  input  logic             tick,
  input  logic             cmp,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] sar_q;
  logic [PTR_W-1:0] ptr_q, idx;
  logic             phase_q;

  assign idx = ptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q   <= '0;
      ptr_q   <= '0;
      phase_q <= 1'b0;
    end else if (at_sample) begin
      sar_q   <= '0;
      ptr_q   <= PTR_W'(RES_W);
      phase_q <= 1'b0;
    end else if (busy && tick && ptr_q != '0) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        sar_q[idx] <= cmp;
        ptr_q      <= idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          result <= '0;
    else if (at_done) result <= sar_q;
  end

  a_r7_bits_before_done: assert property (@(posedge clk) disable iff (rst)
    at_done |-> ptr_q == '0);
endmodule

// File: rtl/adc_shadow.sv
module adc_shadow #(
  parameter int MUX_W = 4,
  parameter int REF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_win,
  input  logic [MUX_W-1:0] mux_wr,
  input  logic [REF_W-1:0] ref_wr,
  output logic [MUX_W-1:0] mux_q,
  output logic [REF_W-1:0] ref_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mux_q <= '0;
      ref_q <= '0;
    end else if (open_win) begin
      mux_q <= mux_wr;
      ref_q <= ref_wr;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int MUX_W  = 4,
  parameter int REF_W  = 2,
  parameter int RES_W  = 10,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start_wr,
  input  logic              trig,
  input  logic              auto_en,
  input  logic              free_run,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic [MUX_W-1:0]  mux_wr,
  input  logic [REF_W-1:0]  ref_wr,
  input  logic              cmp,
  input  logic              flag_clr,
  output logic [MUX_W-1:0]  mux_q,
  output logic [REF_W-1:0]  ref_q,
  output logic              sample_o,
  output logic [RES_W-1:0]  result_o,
  output logic              flag_o
);
  logic              tick, busy, go, at_sample, at_done, open_win;
  logic [PSEL_W-1:0] sel_q;

  adc_prescaler #(.PSEL_W(PSEL_W)) u_presc (
    .clk(clk), .rst(rst), .restart(go), .run(busy), .sel(sel_q), .tick(tick)
  );

  adc_sequencer #(.PSEL_W(PSEL_W)) u_seq (
    .clk(clk), .rst(rst), .enable(enable), .start_wr(start_wr), .trig(trig),
    .auto_en(auto_en), .free_run(free_run), .presc_sel(presc_sel), .tick(tick),
    .busy(busy), .sel_q(sel_q), .go(go), .at_sample(at_sample),
    .at_done(at_done), .open_win(open_win)
  );

  adc_sar #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst(rst), .at_sample(at_sample), .at_done(at_done),
    .busy(busy), .tick(tick), .cmp(cmp), .result(result_o)
  );

  adc_shadow #(.MUX_W(MUX_W), .REF_W(REF_W)) u_shadow (
    .clk(clk), .rst(rst), .open_win(open_win), .mux_wr(mux_wr),
    .ref_wr(ref_wr), .mux_q(mux_q), .ref_q(ref_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_o <= 1'b0;
      flag_o   <= 1'b0;
    end else begin
      sample_o <= at_sample;
      if (at_done)       flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
    end
  end

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    flag_o && !flag_clr |=> flag_o);
  a_r9_frozen_at_sample: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> $stable(mux_q) && $stable(ref_q));
  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o);
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1, enable = 1'b1, start_wr = 1'b0, trig = 1'b0;
  logic       auto_en = 1'b0, free_run = 1'b0, cmp = 1'b0, flag_clr = 1'b0;
  logic [2:0] presc_sel = '0;
  logic [3:0] mux_wr = '0, mux_q;
  logic [1:0] ref_wr = '0, ref_q;
  logic       sample_o, flag_o;
  logic [9:0] result_o, vin = '0;

  int cyc = 0, ncnt = -1, cur_h = 1, nchk = 0, nfail = 0;

  adc_seq_top u_dut (
    .clk(clk), .rst(rst), .enable(enable), .start_wr(start_wr), .trig(trig),
    .auto_en(auto_en), .free_run(free_run), .presc_sel(presc_sel),
    .mux_wr(mux_wr), .ref_wr(ref_wr), .cmp(cmp), .flag_clr(flag_clr),
    .mux_q(mux_q), .ref_q(ref_q), .sample_o(sample_o), .result_o(result_o),
    .flag_o(flag_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  // comparator model: drives bit 9-k of vin before decision edge k
  always @(negedge clk) begin
    if (sample_o) ncnt = 0;
    else if (ncnt >= 0) ncnt = ncnt + 1;
    cmp = 1'b0;
    if (ncnt >= 0 && ((ncnt + 1) % (2 * cur_h)) == 0) begin
      int k;
      k = (ncnt + 1) / (2 * cur_h) - 1;
      if (k <= 9) cmp = vin[9 - k];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  function automatic int samp_of(int mode);
    return (mode == 0) ? 27 : (mode == 2) ? 4 : 7;
  endfunction
  function automatic int tot_of(int mode);
    return (mode == 0) ? 50 : (mode == 2) ? 32 : 31;
  endfunction

  task automatic run_conv(input int sel, input int mode, input logic [9:0] v,
                          input bit use_trig, input bit poke);
    int h, s, t, ew, eb, es, ed;
    string tg;
    logic [3:0] ma, mb;
    logic [1:0] ra, rb;
    bit seen;
    h = 1 << sel; s = samp_of(mode); t = tot_of(mode);
    tg = (mode == 0) ? "R3/R12" : (mode == 2) ? "R5" : "R4";
    ma = 4'($urandom); mb = ma ^ 4'(1 + $urandom % 15);
    ra = 2'($urandom); rb = ~ra;
    @(negedge clk);
    presc_sel = 3'(sel); vin = v; cur_h = h; mux_wr = ma; ref_wr = ra;
    if (use_trig) trig = 1'b1; else start_wr = 1'b1;
    ew = cyc + 1;
    @(negedge clk);
    start_wr = 1'b0; trig = 1'b0;
    @(negedge clk);
    eb = ew + 1;
    chk(mux_q == ma && ref_q == ra, "R9 copy on start edge", mux_q, ma);
    mux_wr = mb; ref_wr = rb; presc_sel = 3'((sel + 1) % 4);
    es = eb + s * h; ed = eb + t * h;
    while (cyc < ed) begin
      @(negedge clk);
      start_wr = (poke && cyc == eb + 3);
      if (cyc == es - 1) chk(sample_o == 1'b0, {tg, "/R2 strobe early"}, sample_o, 0);
      if (cyc == es)     chk(sample_o == 1'b1, {tg, "/R2 strobe"}, sample_o, 1);
      if (cyc == eb + (t - 16) * h)
        chk(mux_q == ma && ref_q == ra, "R9 frozen", mux_q, ma);
      if (cyc == eb + (t - 16) * h + 1)
        chk(mux_q == mb && ref_q == rb, "R9 reopen", mux_q, mb);
      if (cyc == ed - 1) chk(flag_o == 1'b0, {tg, "/R6 flag early"}, flag_o, 0);
      if (cyc == ed) begin
        chk(flag_o == 1'b1, {tg, "/R6 flag time"}, flag_o, 1);
        chk(result_o == v, "R7 result", result_o, v);
      end
    end
    start_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(flag_o == 1'b1, "R8 flag held", flag_o, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(flag_o == 1'b0, "R8 flag cleared", flag_o, 0);
    if (poke) begin
      seen = 0;
      repeat (60 * h) begin
        @(negedge clk);
        if (sample_o || flag_o) seen = 1;
      end
      chk(!seen, "R11 busy start ignored", seen, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int h, ed1;
    bit seen;
    logic [9:0] v2;
    void'($urandom(32'd4242));
    mux_wr = 4'hA; ref_wr = 2'h3;
    repeat (3) @(negedge clk);
    chk(flag_o == 0 && sample_o == 0, "R1 flag/strobe reset", flag_o, 0);
    chk(result_o == 0, "R1 result reset", result_o, 0);
    chk(mux_q == 0 && ref_q == 0, "R1 shadow reset", mux_q, 0);
    rst = 1'b0;

    run_conv(0, 0, 10'h2A5, 0, 0);
    run_conv(2, 1, 10'h3FF, 0, 1);
    auto_en = 1'b1;
    run_conv(1, 2, 10'h001, 1, 0);
    auto_en = 1'b0;

    // trig without auto_en
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    seen = 0;
    repeat (100) begin @(negedge clk); if (sample_o || flag_o) seen = 1; end
    chk(!seen, "R5 trig ignored", seen, 0);

    // largest prescale
    run_conv(7, 1, 10'h155, 0, 0);

    // re-enable gives first timing again
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    run_conv(1, 0, 10'h0F0, 0, 0);

    // free-running chain
    h = 2; cur_h = h; v2 = 10'h19C;
    @(negedge clk);
    presc_sel = 3'd1; vin = 10'h2C3; free_run = 1'b1; start_wr = 1'b1;
    ed1 = cyc + 2 + 31 * h;
    @(negedge clk); start_wr = 1'b0;
    while (cyc < ed1) @(negedge clk);
    chk(flag_o == 1'b1, "R10 first done", flag_o, 1);
    chk(result_o == 10'h2C3, "R10 first result", result_o, 10'h2C3);
    free_run = 1'b0; vin = v2; flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    while (cyc < ed1 + 31 * h) begin
      @(negedge clk);
      if (cyc == ed1 + 7 * h) chk(sample_o == 1'b1, "R10 chained strobe", sample_o, 1);
      if (cyc == ed1 + 31 * h - 1) chk(flag_o == 1'b0, "R10 chained flag early", flag_o, 0);
    end
    chk(flag_o == 1'b1, "R10 chained done", flag_o, 1);
    chk(result_o == v2, "R10 chained result", result_o, v2);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    seen = 0;
    repeat (80 * h) begin @(negedge clk); if (sample_o || flag_o) seen = 1; end
    chk(!seen, "R10 chain stopped", seen, 0);

    // clear and completion on the same edge: set wins
    @(negedge clk); presc_sel = 3'd0; cur_h = 1; vin = 10'h0AA; start_wr = 1'b1;
    ed1 = cyc + 2 + 31;
    @(negedge clk); start_wr = 1'b0;
    while (cyc < ed1 - 1) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk(flag_o == 1'b1, "R8 set beats clear", flag_o, 1);
    flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;

    // random mix
    auto_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      int m;
      m = ($urandom % 2 == 0) ? 1 : 2;
      run_conv(int'($urandom % 4), m, 10'($urandom), m == 2, bit'($urandom % 3 == 0));
    end

    summary();
    $finish;
  end
endmodule